// File: doc/BRIEF.md
# Scanning RAM Test Engine

This block tests a byte-wide synchronous RAM over a fixed, inclusive address window. It runs in scans. In each scan it writes a single test byte to every address of the window in ascending order. It then reads the whole window back in the same order and compares each returned byte with the test byte. The test byte starts at zero for each run and goes up by one after every completed scan. The engine keeps scanning until it sees a mismatch or receives an abort request.

Every fixed number of completed scans (256 by default), a one-cycle progress pulse tells the surrounding logic that the engine is still running.

On the first mismatch the engine stops issuing RAM cycles. It then holds the failing address, the byte it expected and the byte the RAM returned, until the next start. An abort stops the run at any point and leaves the error indication clear. A one-cycle done pulse marks the end of every run, whether it ended by failure or by abort.

Top module: `ram_scan_tester`

## Requirements
- R1: While busy, the RAM address stays inside the window WIN_LO..WIN_HI. Every address of the window is written once per scan, in ascending order starting at WIN_LO, and no address outside the window is ever written.
- R2: Within a scan, all window writes come before any read. The read phase then walks the window in ascending order with write enable low.
- R3: Every write of a scan carries the same byte. The first scan after start uses 0x00, each later scan uses the previous byte plus one, and 0xFF is followed by 0x00.
- R4: The byte returned one cycle after a read address is issued is compared against the current test byte. This includes the read of WIN_HI at the end of the read phase.
- R5: On a mismatch the engine goes idle and sets `fail`. It reports the failing address on `fail_addr`, the test byte on `fail_exp` and the returned byte on `fail_obs`. No RAM write follows.
- R6: When several addresses would mismatch in one scan, the lowest (first read) address is the one reported.
- R7: `progress` pulses high for one cycle each time a multiple of PROG_SCANS scans has completed. The pulse falls in the same cycle as the write to WIN_LO that opens the following scan.
- R8: `abort` while busy returns the engine to idle on the next clock edge, from either phase. It leaves `fail` low and stops all RAM writes.
- R9: `fail` and the three captured fields hold their values while idle, until a start clears `fail`.
- R10: `start` while busy has no effect: the test byte sequence continues unbroken. `abort` while idle has no effect: a held failure stays visible.
- R11: After reset the engine is idle, with `busy`, `ram_we`, `fail`, `progress` and `done` all low.
- R12: `done` is a single-cycle pulse in the first idle cycle after any run ends, whether by mismatch or by abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (sampled while idle) |
| abort | input | 1 | Stop the current run without error |
| ram_addr | output | ADDR_W | RAM address |
| ram_wdata | output | DATA_W | RAM write data (current test byte) |
| ram_we | output | 1 | RAM write enable |
| ram_rdata | input | DATA_W | RAM read data, valid one cycle after the address |
| busy | output | 1 | A run is in progress |
| progress | output | 1 | One-cycle pulse every PROG_SCANS completed scans |
| done | output | 1 | One-cycle pulse when a run ends |
| fail | output | 1 | Mismatch seen; held until next start |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_exp | output | DATA_W | Test byte expected there |
| fail_obs | output | DATA_W | Byte actually returned |

## Verification
The checker assumes that `start` and `abort` are synchronous to `clk`, and that `ram_rdata` always comes from a RAM with exactly one cycle of read latency. The done-pulse and abort properties also assume the controller sees inputs only on clock edges.

The bench drives every input on the falling edge. Its RAM model always registers the read data. Faults are injected only in that model's read path, gated by the stored byte value, so a failure shows up in a chosen scan without ever violating the latency the compare relies on.

// File: rtl/ramtest_pkg.sv
package ramtest_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WRITE = 2'd1,
      ST_READ  = 2'd2,
      ST_DRAIN = 2'd3
   } rt_state_e;
endpackage

// File: rtl/rt_addr_seq.sv
module rt_addr_seq #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned WIN_LO = 'h0040,
   parameter int unsigned WIN_HI = 'h9FFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   output logic [ADDR_W-1:0] addr,
   output logic              at_last
);
   localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(WIN_LO);
   localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(WIN_HI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    addr <= LO_A;
      else if (load) addr <= LO_A;
      else if (step) addr <= addr + 1'b1;
   end

   assign at_last = (addr == HI_A);
endmodule

// File: rtl/rt_pattern_gen.sv
module rt_pattern_gen #(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned PROG_SCANS = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              scan_done,
   output logic [DATA_W-1:0] pattern,
   output logic              progress
);
   localparam int unsigned CNT_W = $clog2(PROG_SCANS);
   localparam bit          POW2  = ((PROG_SCANS & (PROG_SCANS - 1)) == 0);

   logic [CNT_W-1:0] scan_cnt;
   logic             wrap;

   generate
      if (POW2) begin : g_pow2
         assign wrap = &scan_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         scan_cnt <= '0;
            else if (clear)     scan_cnt <= '0;
            else if (scan_done) scan_cnt <= scan_cnt + 1'b1;
         end
      end else begin : g_mod
         assign wrap = (scan_cnt == CNT_W'(PROG_SCANS - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         scan_cnt <= '0;
            else if (clear)     scan_cnt <= '0;
            else if (scan_done) scan_cnt <= wrap ? '0 : scan_cnt + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pattern  <= '0;
         progress <= 1'b0;
      end else begin
         progress <= scan_done && wrap && !clear;
         if (clear)          pattern <= '0;
         else if (scan_done) pattern <= pattern + 1'b1;
      end
   end
endmodule

// File: rtl/rt_compare.sv
module rt_compare #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic [ADDR_W-1:0] issue_addr,
   input  logic [DATA_W-1:0] rdata,
   input  logic [DATA_W-1:0] pattern,
   output logic              mismatch,
   output logic [ADDR_W-1:0] pend_addr
);
   logic pend_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_valid <= 1'b0;
         pend_addr  <= '0;
      end else begin
         pend_valid <= issue;
         if (issue) pend_addr <= issue_addr;
      end
   end

   assign mismatch = pend_valid && (rdata != pattern);
endmodule

// File: rtl/ram_scan_tester.sv
module ram_scan_tester
   import ramtest_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned WIN_LO     = 'h0040,
   parameter int unsigned WIN_HI     = 'h9FFF,
   parameter int unsigned PROG_SCANS = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              abort,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [DATA_W-1:0] ram_wdata,
   output logic              ram_we,
   input  logic [DATA_W-1:0] ram_rdata,
   output logic              busy,
   output logic              progress,
   output logic              done,
   output logic              fail,
   output logic [ADDR_W-1:0] fail_addr,
   output logic [DATA_W-1:0] fail_exp,
   output logic [DATA_W-1:0] fail_obs
);
   generate
      if (WIN_HI < WIN_LO) begin : g_bad_window
         $error("ram_scan_tester: WIN_HI below WIN_LO");
      end
      if (ADDR_W < 32 && WIN_HI >= (32'd1 << ADDR_W)) begin : g_bad_width
         $error("ram_scan_tester: window exceeds address width");
      end
      if (PROG_SCANS < 2) begin : g_bad_prog
         $error("ram_scan_tester: PROG_SCANS must be at least 2");
      end
   endgenerate

   rt_state_e         state, nxt;
   logic              addr_load, addr_step, at_last;
   logic              scan_done, issue, mismatch;
   logic [ADDR_W-1:0] addr, pend_addr;
   logic [DATA_W-1:0] pattern;
   logic              launch, aborting;

   assign launch   = start && (state == ST_IDLE);
   assign aborting = abort && (state != ST_IDLE);

   always_comb begin
      nxt       = state;
      addr_load = 1'b0;
      addr_step = 1'b0;
      scan_done = 1'b0;
      issue     = 1'b0;
      unique case (state)
         ST_IDLE: begin
            if (start) begin
               nxt       = ST_WRITE;
               addr_load = 1'b1;
            end
         end
         ST_WRITE: begin
            if (at_last) begin
               nxt       = ST_READ;
               addr_load = 1'b1;
            end else begin
               addr_step = 1'b1;
            end
         end
         ST_READ: begin
            if (mismatch) begin
               nxt = ST_IDLE;
            end else begin
               issue = 1'b1;
               if (at_last) nxt = ST_DRAIN;
               else         addr_step = 1'b1;
            end
         end
         ST_DRAIN: begin
            if (mismatch) begin
               nxt = ST_IDLE;
            end else begin
               nxt       = ST_WRITE;
               addr_load = 1'b1;
               scan_done = 1'b1;
            end
         end
         default: nxt = ST_IDLE;
      endcase
      if (aborting) begin
         nxt       = ST_IDLE;
         scan_done = 1'b0;
         issue     = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         done  <= 1'b0;
      end else begin
         state <= nxt;
         done  <= (state != ST_IDLE) && (nxt == ST_IDLE);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fail      <= 1'b0;
         fail_addr <= '0;
         fail_exp  <= '0;
         fail_obs  <= '0;
      end else if (launch) begin
         fail <= 1'b0;
      end else if (mismatch && !aborting && state != ST_IDLE) begin
         fail      <= 1'b1;
         fail_addr <= pend_addr;
         fail_exp  <= pattern;
         fail_obs  <= ram_rdata;
      end
   end

   rt_addr_seq #(
      .ADDR_W(ADDR_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
   ) u_addr (
      .clk(clk), .rst_n(rst_n), .load(addr_load), .step(addr_step),
      .addr(addr), .at_last(at_last)
   );

   rt_pattern_gen #(
      .DATA_W(DATA_W), .PROG_SCANS(PROG_SCANS)
   ) u_pat (
      .clk(clk), .rst_n(rst_n), .clear(launch), .scan_done(scan_done),
      .pattern(pattern), .progress(progress)
   );

   rt_compare #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_cmp (
      .clk(clk), .rst_n(rst_n), .issue(issue), .issue_addr(addr),
      .rdata(ram_rdata), .pattern(pattern), .mismatch(mismatch),
      .pend_addr(pend_addr)
   );

   assign ram_addr  = addr;
   assign ram_wdata = pattern;
   assign ram_we    = (state == ST_WRITE);
   assign busy      = (state != ST_IDLE);
endmodule

// File: rtl/ram_scan_tester_chk.sv
module ram_scan_tester_chk #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned WIN_LO = 'h0040,
   parameter int unsigned WIN_HI = 'h9FFF
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              abort,
   input logic [ADDR_W-1:0] ram_addr,
   input logic [DATA_W-1:0] ram_wdata,
   input logic              ram_we,
   input logic              busy,
   input logic              progress,
   input logic              done,
   input logic              fail,
   input logic [ADDR_W-1:0] fail_addr
);
   localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(WIN_LO);
   localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(WIN_HI);

   p_addr_in_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (ram_addr >= LO_A && ram_addr <= HI_A));

   p_write_ascending_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we && $past(ram_we) |-> ram_addr == $past(ram_addr) + 1'b1);

   p_byte_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we && $past(ram_we) |-> $stable(ram_wdata));

   p_no_write_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> busy);

   p_progress_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
      progress |-> ram_we && ram_addr == LO_A);

   p_abort_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
      abort && busy |=> !busy && !fail && done);

   p_fail_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fail && !start |=> fail && $stable(fail_addr));

   p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

bind ram_scan_tester ram_scan_tester_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
   .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
   .busy(busy), .progress(progress), .done(done), .fail(fail),
   .fail_addr(fail_addr)
);

// File: tb/ram_scan_tester_tb.sv
module ram_scan_tester_tb;
   localparam int unsigned AW = 16;
   localparam int unsigned DW = 8;
   localparam int unsigned LO = 'h0040;
   localparam int unsigned HI = 'h004F;
   localparam int unsigned NWIN = HI - LO + 1;
   localparam int unsigned PS = 256;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic abort = 1'b0;
   logic [AW-1:0] ram_addr;
   logic [DW-1:0] ram_wdata, ram_rdata;
   logic ram_we, busy, progress, done, fail;
   logic [AW-1:0] fail_addr;
   logic [DW-1:0] fail_exp, fail_obs;

   always #10 clk = ~clk;

   ram_scan_tester #(
      .ADDR_W(AW), .DATA_W(DW), .WIN_LO(LO), .WIN_HI(HI), .PROG_SCANS(PS)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
      .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
      .ram_rdata(ram_rdata), .busy(busy), .progress(progress), .done(done),
      .fail(fail), .fail_addr(fail_addr), .fail_exp(fail_exp),
      .fail_obs(fail_obs)
   );

   // RAM model: one-cycle read latency, faults injected on the read path
   logic [DW-1:0] mem [0:255];
   logic          f0_en = 1'b0, f1_en = 1'b0;
   logic [AW-1:0] f0_addr = '0, f1_addr = '0;
   logic [DW-1:0] f0_val = '0, f1_val = '0, f0_mask = '0, f1_mask = '0;

   initial for (int i = 0; i < 256; i++) mem[i] = 8'hAA;

   always @(posedge clk) begin
      logic [DW-1:0] v;
      v = mem[ram_addr[7:0]];
      if (f0_en && ram_addr == f0_addr && v == f0_val) v = v ^ f0_mask;
      if (f1_en && ram_addr == f1_addr && v == f1_val) v = v ^ f1_mask;
      ram_rdata <= v;
      if (ram_we) mem[ram_addr[7:0]] <= ram_wdata;
   end

   int checks = 0;
   int failures = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // Port monitor on the falling edge
   int exp_scan = 0;
   int wr_in_scan = 0;
   int win_err = 0, pat_err = 0, ord_err = 0, prog_err = 0, prog_cnt = 0;
   int writes_seen = 0;
   logic [DW-1:0] cur_pat = '0;
   logic [AW-1:0] next_wr = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (progress) begin
            prog_cnt++;
            if (exp_scan == 0 || (exp_scan % PS) != 0 || !ram_we || ram_addr != AW'(LO))
               prog_err++;
         end
         if (ram_we) begin
            writes_seen++;
            if (ram_addr < AW'(LO) || ram_addr > AW'(HI)) win_err++;
            if (ram_addr == AW'(LO)) begin
               if (ram_wdata != DW'(exp_scan)) pat_err++;
               cur_pat = ram_wdata;
               exp_scan++;
               wr_in_scan = 0;
            end else begin
               if (ram_wdata != cur_pat) pat_err++;
               if (ram_addr != next_wr) ord_err++;
            end
            next_wr = ram_addr + 1'b1;
            wr_in_scan++;
         end else if (busy) begin
            if (ram_addr < AW'(LO) || ram_addr > AW'(HI)) win_err++;
            if (wr_in_scan != NWIN) ord_err++;
         end
      end
   end

   task automatic start_run();
      @(negedge clk);
      exp_scan = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(output bit seen);
      seen = 1'b0;
      for (int i = 0; i < 60000; i++) begin
         @(negedge clk);
         if (done) begin
            seen = 1'b1;
            break;
         end
      end
   endtask

   task automatic t_reset();
      chk(!busy && !ram_we, "R11 idle/we after reset", {busy, ram_we}, 0);
      chk(!fail && !progress && !done, "R11 flags after reset", {fail, progress, done}, 0);
   endtask

   task automatic t_first_scan_fault();
      bit seen;
      int w;
      f0_en = 1'b1; f0_addr = AW'('h45); f0_val = 8'h00; f0_mask = 8'h10;
      start_run();
      wait_done(seen);
      chk(seen, "R12 done after mismatch", seen, 1);
      chk(fail, "R5 fail set", fail, 1);
      chk(fail_addr == AW'('h45), "R5 fail_addr", fail_addr, 'h45);
      chk(fail_exp == 8'h00 && fail_obs == 8'h10, "R5 exp/obs", {fail_exp, fail_obs}, 'h0010);
      @(negedge clk);
      chk(!done, "R12 done one cycle", done, 0);
      w = writes_seen;
      repeat (20) @(negedge clk);
      chk(writes_seen == w && !busy, "R5 no writes after fail", writes_seen - w, 0);
      for (int a = LO; a <= HI; a++)
         chk(mem[a] == 8'h00, "R1 window byte written", mem[a], 0);
      chk(mem[LO-1] == 8'hAA && mem[HI+1] == 8'hAA, "R1 outside untouched",
          {mem[LO-1], mem[HI+1]}, 'hAAAA);
      chk(win_err == 0 && ord_err == 0, "R2 order and window", win_err + ord_err, 0);
      f0_en = 1'b0;
   endtask

   task automatic t_last_addr_fault();
      bit seen;
      f0_en = 1'b1; f0_addr = AW'(HI); f0_val = 8'h03; f0_mask = 8'h80;
      start_run();
      wait_done(seen);
      chk(fail && fail_addr == AW'(HI), "R4 drain compare at WIN_HI", fail_addr, HI);
      chk(fail_exp == 8'h03 && fail_obs == 8'h83, "R4 exp/obs", {fail_exp, fail_obs}, 'h0383);
      chk(exp_scan == 4 && pat_err == 0, "R3 byte per scan", exp_scan, 4);
      f0_en = 1'b0;
   endtask

   task automatic t_two_faults();
      bit seen;
      f0_en = 1'b1; f0_addr = AW'('h4A); f0_val = 8'h01; f0_mask = 8'h01;
      f1_en = 1'b1; f1_addr = AW'('h41); f1_val = 8'h01; f1_mask = 8'h40;
      start_run();
      wait_done(seen);
      chk(fail && fail_addr == AW'('h41), "R6 first mismatch reported", fail_addr, 'h41);
      chk(fail_obs == 8'h41, "R6 obs", fail_obs, 'h41);
      f0_en = 1'b0; f1_en = 1'b0;
   endtask

   task automatic t_hold_and_clear();
      logic [AW-1:0] a;
      a = fail_addr;
      repeat (30) @(negedge clk);
      chk(fail && fail_addr == a, "R9 fail held", fail_addr, a);
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      @(negedge clk);
      chk(fail && !busy && !done, "R10 abort idle ignored", {fail, busy, done}, 'b100);
      start_run();
      chk(!fail && busy, "R9 start clears fail", {fail, busy}, 'b01);
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
   endtask

   task automatic t_long_run();
      int w;
      bit hung;
      prog_cnt = 0; prog_err = 0; pat_err = 0;
      start_run();
      hung = 1'b1;
      for (int i = 0; i < 40000; i++) begin
         @(negedge clk);
         if (exp_scan == 100 && ram_we && ram_addr == AW'(LO + 3)) begin
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
         end
         if (exp_scan >= 515) begin
            hung = 1'b0;
            break;
         end
      end
      chk(!hung, "R3 long run reaches 515 scans", exp_scan, 515);
      chk(pat_err == 0, "R3 byte sequence incl. wrap, R10 start ignored", pat_err, 0);
      chk(prog_cnt == 2 && prog_err == 0, "R7 progress pulses", prog_cnt, 2);
      while (!(busy && !ram_we)) @(negedge clk);
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      chk(!busy && !fail && done, "R8 abort in read phase", {busy, fail, done}, 'b001);
      chk(win_err == 0 && ord_err == 0, "R1 window over long run", win_err + ord_err, 0);
   endtask

   task automatic t_abort_write();
      int w;
      start_run();
      repeat (5) @(negedge clk);
      chk(ram_we, "R8 in write phase", ram_we, 1);
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      chk(!busy && !fail && done, "R8 abort in write phase", {busy, fail, done}, 'b001);
      w = writes_seen;
      repeat (20) @(negedge clk);
      chk(writes_seen == w, "R8 writes stop after abort", writes_seen - w, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_first_scan_fault();
      t_last_addr_fault();
      t_two_faults();
      t_hold_and_clear();
      t_long_run();
      t_abort_write();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule